// File: doc/BRIEF.md
# Eight-Input Prioritised Interrupt Controller

This block gathers eight interrupt request lines and presents a single interrupt line to a processor. Software sets it up through a byte-wide register port with a one-bit address. A configuration sequence fixes the vector base, the cascade wiring word, the trigger style (edge or level) and the end-of-interrupt style. After that, the same port loads the mask, issues end-of-interrupt commands, turns special-mask operation on or off, and chooses which status register a read returns.

Inside, the block keeps three registers: pending requests, requests in service and the mask. A fixed-priority resolver picks the winning input, with input 0 the most urgent. When the processor pulses acknowledge, the block returns the vector for the winner, which is the base plus the input number, and records that input as in service. In auto-EOI mode it does not record the input. The cascade word and the mode word are stored and exposed on configuration outputs. Signalling across several chained controllers is not modelled.

Top module: `pic8_core`

## Requirements
- R1: After reset the mask is 0xFF, no request or in-service bit is set, `irq_out` is low, a read at address 0 returns the request register and a read at address 1 returns the mask.
- R2: A write to address 0 with data bit 4 set starts configuration. It clears the mask, the in-service register and special-mask mode, selects reading the request register and clears the stored mode word. From its data it keeps bit 3 as the trigger style (1 = level), bit 1 as single-controller operation and bit 0 as "mode word follows".
- R3: The configuration words that follow go to address 1 in this order: vector base, cascade word, mode word. The cascade word is skipped when bit 1 was set, and the mode word is skipped when bit 0 was clear. Once the sequence is complete, writes to address 1 load the mask. The stored cascade word appears on `cfg_cascade` and the mode word appears on `cfg_mode`.
- R4: During an acknowledge cycle, `vec_out` equals the vector base plus the number of the winning input, modulo 256. If no input qualifies, it equals the base plus 7.
- R5: A set mask bit keeps the matching input from raising `irq_out`.
- R6: Priority is fixed, with input 0 highest. Outside special-mask mode, an unmasked request raises `irq_out` only if its number is lower than that of every in-service bit.
- R7: An acknowledge sets the winner's in-service bit. In edge mode it also clears the winner's request bit.
- R8: A write to address 0 with bits 4:3 = 00 and bits 7:5 = 001 clears the lowest-numbered in-service bit.
- R9: When mode-word bit 1 (auto-EOI) is set, an acknowledge leaves the in-service register unchanged.
- R10: A write to address 0 with bits 4:3 = 01 is a control word. If bits 6:5 = 11 it sets special-mask mode, and if they are 10 it clears it. If bits 1:0 = 10 it selects the request register for reads at address 0, and if they are 11 it selects the in-service register.
- R11: In special-mask mode, any unmasked request whose own in-service bit is clear raises `irq_out`, whatever other bits are in service.
- R12: In edge mode a rising input sets its request bit one clock later, and the bit stays set after the input falls. In level mode the request register follows the inputs with one clock of lag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 1 | Register address for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from `bus_addr`) |
| irq_in | input | 8 | Interrupt request inputs |
| irq_out | output | 1 | Interrupt request to the processor |
| inta | input | 1 | Acknowledge pulse, one cycle |
| vec_out | output | 8 | Vector, valid while `inta` is high |
| cfg_cascade | output | 8 | Stored cascade word |
| cfg_mode | output | 5 | Stored mode word |

## Verification
The assertions assume that every write and every acknowledge lasts exactly one cycle, and that an end-of-interrupt command never falls in the same cycle as an acknowledge or a configuration start. The bench drives writes and acknowledges from separate tasks that run one after another, so these events never overlap. Request inputs change only on falling edges, and each new edge-mode request follows a low period on that line, so every rising edge is seen.

// File: rtl/pic8_pkg.sv
package pic8_pkg;
    localparam int PIC_N = 8;
    localparam int IDX_W = $clog2(PIC_N);
    localparam int MODE_W = 5;

    typedef enum logic [1:0] {
        ST_READY,
        ST_BASE,
        ST_CASC,
        ST_MODE
    } init_st_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } pick_t;

    typedef struct packed {
        logic [7:0]        base;
        logic [7:0]        cascade;
        logic [MODE_W-1:0] mode;
        logic              level;
        logic              single;
        logic              want_mode;
    } cfg_t;

    // Lowest-numbered set bit (highest priority).
    function automatic pick_t first_set(input logic [PIC_N-1:0] v);
        pick_t r;
        r.hit = 1'b0;
        r.idx = '0;
        for (int i = PIC_N - 1; i >= 0; i--) begin
            if (v[i]) begin
                r.hit = 1'b1;
                r.idx = IDX_W'(i);
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/pic8_ctrl.sv
module pic8_ctrl
    import pic8_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic             addr,
    input  logic [7:0]       wdata,
    output cfg_t             cfg,
    output logic [PIC_N-1:0] mask,
    output logic             smm,
    output logic             rd_isr,
    output logic             eoi,
    output logic             init_go
);
    init_st_t st;

    wire wr0 = we && !addr;
    wire wr1 = we && addr;
    wire is_icw1 = wr0 && wdata[4];
    wire is_ocw3 = wr0 && !wdata[4] && wdata[3];

    assign init_go = is_icw1;
    assign eoi = wr0 && wdata[4:3] == 2'b00 && wdata[7:5] == 3'b001;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_READY;
            cfg    <= '0;
            mask   <= '1;
            smm    <= 1'b0;
            rd_isr <= 1'b0;
        end else if (is_icw1) begin
            st            <= ST_BASE;
            cfg.level     <= wdata[3];
            cfg.single    <= wdata[1];
            cfg.want_mode <= wdata[0];
            cfg.mode      <= '0;
            mask          <= '0;
            smm           <= 1'b0;
            rd_isr        <= 1'b0;
        end else begin
            if (is_ocw3) begin
                if (wdata[6]) smm <= wdata[5];
                if (wdata[1]) rd_isr <= wdata[0];
            end
            if (wr1) begin
                unique case (st)
                    ST_BASE: begin
                        cfg.base <= wdata;
                        if (!cfg.single) st <= ST_CASC;
                        else if (cfg.want_mode) st <= ST_MODE;
                        else st <= ST_READY;
                    end
                    ST_CASC: begin
                        cfg.cascade <= wdata;
                        st <= cfg.want_mode ? ST_MODE : ST_READY;
                    end
                    ST_MODE: begin
                        cfg.mode <= wdata[MODE_W-1:0];
                        st <= ST_READY;
                    end
                    default: mask <= wdata;
                endcase
            end
        end
    end

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr1 && !wdata[4] && st == ST_READY && !is_icw1) |=> (mask == $past(wdata))); // R5

    AST_INIT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        is_icw1 |=> (mask == '0 && !rd_isr && !smm && st == ST_BASE)); // R2

    AST_SMM_SET: assert property (@(posedge clk) disable iff (rst)
        (is_ocw3 && wdata[6:5] == 2'b11) |=> smm); // R10
endmodule

// File: rtl/pic8_req.sv
module pic8_req
    import pic8_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             level,
    input  logic [PIC_N-1:0] irq_in,
    input  logic [PIC_N-1:0] ack_clr,
    output logic [PIC_N-1:0] irr
);
    logic [PIC_N-1:0] prev;
    logic [PIC_N-1:0] rise;

    assign rise = irq_in & ~prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= '0;
            irr  <= '0;
        end else begin
            prev <= irq_in;
            if (level) irr <= irq_in;
            else irr <= (irr & ~ack_clr) | rise;
        end
    end

    AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (rst)
        (!level && rise != '0) |=> ((irr & $past(rise)) == $past(rise))); // R12

    AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        level |=> (irr == $past(irq_in))); // R12
endmodule

// File: rtl/pic8_prio.sv
module pic8_prio
    import pic8_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [PIC_N-1:0] irr,
    input  logic [PIC_N-1:0] mask,
    input  logic             smm,
    input  logic             aeoi,
    input  logic             level,
    input  logic             inta,
    input  logic             eoi,
    input  logic             init_go,
    output logic [PIC_N-1:0] isr,
    output logic             int_req,
    output logic [IDX_W-1:0] win_idx,
    output logic [PIC_N-1:0] ack_clr
);
    logic [PIC_N-1:0] elig;
    pick_t            win;
    pick_t            top;
    logic [PIC_N-1:0] isr_nx;

    always_comb begin
        elig = irr & ~mask;
        if (smm) elig = elig & ~isr;
        win = first_set(elig);
        top = first_set(isr);
        if (smm || !top.hit) int_req = win.hit;
        else int_req = win.hit && (win.idx < top.idx);
    end

    assign win_idx = int_req ? win.idx : IDX_W'(PIC_N - 1);
    assign ack_clr = (inta && int_req && !level) ? (PIC_N'(1) << win.idx) : '0;

    always_comb begin
        isr_nx = isr;
        if (eoi && top.hit) isr_nx[top.idx] = 1'b0;
        if (inta && int_req && !aeoi) isr_nx[win.idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || init_go) isr <= '0;
        else isr <= isr_nx;
    end

    AST_ACK_SETS: assert property (@(posedge clk) disable iff (rst)
        (inta && int_req && !aeoi && !init_go) |=> isr[$past(win.idx)]); // R7

    AST_AEOI_KEEP: assert property (@(posedge clk) disable iff (rst)
        (inta && aeoi && !eoi && !init_go) |=> (isr == $past(isr))); // R9

    AST_EOI_DROP: assert property (@(posedge clk) disable iff (rst)
        (eoi && isr != '0 && !inta && !init_go)
        |=> ($countones(isr) + 1 == $countones($past(isr)))); // R8

    AST_NEST_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (!smm && isr[0] && !(elig[0] && !isr[0])) |-> !int_req); // R6
endmodule

// File: rtl/pic8_core.sv
module pic8_core
    import pic8_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_we,
    input  logic        bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic [7:0]  irq_in,
    output logic        irq_out,
    input  logic        inta,
    output logic [7:0]  vec_out,
    output logic [7:0]  cfg_cascade,
    output logic [4:0]  cfg_mode
);
    cfg_t             cfg;
    logic [PIC_N-1:0] mask;
    logic [PIC_N-1:0] irr;
    logic [PIC_N-1:0] isr;
    logic [PIC_N-1:0] ack_clr;
    logic [IDX_W-1:0] win_idx;
    logic             smm;
    logic             rd_isr;
    logic             eoi;
    logic             init_go;

    pic8_ctrl u_ctrl (
        .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .cfg(cfg), .mask(mask), .smm(smm), .rd_isr(rd_isr),
        .eoi(eoi), .init_go(init_go)
    );

    pic8_req u_req (
        .clk(clk), .rst(rst), .level(cfg.level), .irq_in(irq_in),
        .ack_clr(ack_clr), .irr(irr)
    );

    pic8_prio u_prio (
        .clk(clk), .rst(rst), .irr(irr), .mask(mask), .smm(smm),
        .aeoi(cfg.mode[1]), .level(cfg.level), .inta(inta), .eoi(eoi),
        .init_go(init_go), .isr(isr), .int_req(irq_out),
        .win_idx(win_idx), .ack_clr(ack_clr)
    );

    assign bus_rdata   = bus_addr ? mask : (rd_isr ? isr : irr);
    assign vec_out     = cfg.base + 8'(win_idx);
    assign cfg_cascade = cfg.cascade;
    assign cfg_mode    = cfg.mode;

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mask == '1) |-> !irq_out); // R5
endmodule

// File: tb/pic8_core_tb.sv
module pic8_core_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_we = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] irq_in = '0;
    logic       irq_out;
    logic       inta = 1'b0;
    logic [7:0] vec_out;
    logic [7:0] cfg_cascade;
    logic [4:0] cfg_mode;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] exp_q[$];
    string      req_q[$];

    always #4 clk = ~clk;

    pic8_core u_dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .irq_out(irq_out), .inta(inta), .vec_out(vec_out),
        .cfg_cascade(cfg_cascade), .cfg_mode(cfg_mode)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic a, input string req, input logic [7:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic set_irq(input logic [7:0] v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
    endtask

    task automatic ack(input string req, input logic [7:0] exp);
        @(negedge clk);
        exp_q.push_back(exp);
        req_q.push_back(req);
        inta = 1'b1;
        @(negedge clk);
        inta = 1'b0;
    endtask

    // Monitor: compares each acknowledge vector with the queued expectation.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (inta) begin
                if (exp_q.size() == 0) chk("R4 unexpected ack", vec_out, 8'hxx);
                else chk(req_q.pop_front(), vec_out, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(8 * 100000);
        n_chk++; n_err++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        rd(1'b0, "R1 request reg", 8'h00);
        rd(1'b1, "R1 mask", 8'hFF);
        chk("R1 irq_out", {7'b0, irq_out}, 8'h00);

        // R2 R3 full sequence: edge, cascaded, mode word
        wr(1'b0, 8'h11);
        rd(1'b1, "R2 mask cleared", 8'h00);
        wr(1'b1, 8'h20);
        wr(1'b1, 8'h04);
        wr(1'b1, 8'h01);
        chk("R3 cascade word", cfg_cascade, 8'h04);
        chk("R3 mode word", {3'b0, cfg_mode}, 8'h01);

        // R5 mask
        wr(1'b1, 8'hFF);
        rd(1'b1, "R5 mask readback", 8'hFF);
        set_irq(8'h08);
        chk("R5 masked input quiet", {7'b0, irq_out}, 8'h00);
        set_irq(8'h00);
        rd(1'b0, "R12 edge latched after fall", 8'h08);
        wr(1'b1, 8'hF7);
        chk("R5 unmasked raises", {7'b0, irq_out}, 8'h01);
        ack("R4 vector base+3", 8'h23);
        rd(1'b0, "R7 request cleared", 8'h00);
        wr(1'b0, 8'h0B);
        rd(1'b0, "R10 R7 in-service read", 8'h08);
        chk("R7 irq_out drops", {7'b0, irq_out}, 8'h00);

        // R6 nesting
        wr(1'b1, 8'h00);
        set_irq(8'h20);
        chk("R6 lower blocked", {7'b0, irq_out}, 8'h00);
        set_irq(8'h22);
        chk("R6 higher passes", {7'b0, irq_out}, 8'h01);
        ack("R4 vector base+1", 8'h21);
        rd(1'b0, "R7 nested in-service", 8'h0A);
        set_irq(8'h00);
        wr(1'b0, 8'h20);
        rd(1'b0, "R8 eoi clears lowest", 8'h08);
        chk("R6 still blocked by 3", {7'b0, irq_out}, 8'h00);
        wr(1'b0, 8'h20);
        rd(1'b0, "R8 second eoi", 8'h00);
        chk("R6 pending 5 passes", {7'b0, irq_out}, 8'h01);
        ack("R4 vector base+5", 8'h25);
        wr(1'b0, 8'h20);

        // R11 special mask
        set_irq(8'h40);
        ack("R4 vector base+6", 8'h26);
        set_irq(8'h00);
        set_irq(8'h80);
        chk("R6 input 7 blocked", {7'b0, irq_out}, 8'h00);
        wr(1'b0, 8'h68);
        chk("R11 special mask lets 7", {7'b0, irq_out}, 8'h01);
        ack("R11 vector base+7", 8'h27);
        rd(1'b0, "R11 both in service", 8'hC0);
        wr(1'b0, 8'h48);
        wr(1'b0, 8'h20);
        wr(1'b0, 8'h20);
        rd(1'b0, "R8 all cleared", 8'h00);
        set_irq(8'h00);
        ack("R4 nothing pending base+7", 8'h27);

        // R2 R3 R9 R12: level, single, auto-EOI
        wr(1'b0, 8'h1B);
        rd(1'b1, "R2 mask cleared again", 8'h00);
        rd(1'b0, "R2 request read selected", 8'h00);
        wr(1'b1, 8'h40);
        wr(1'b1, 8'h03);
        chk("R3 mode after skip", {3'b0, cfg_mode}, 8'h03);
        chk("R3 cascade kept", cfg_cascade, 8'h04);
        wr(1'b1, 8'hFE);
        rd(1'b1, "R3 next word is mask", 8'hFE);
        wr(1'b1, 8'h00);
        set_irq(8'h04);
        rd(1'b0, "R12 level follows", 8'h04);
        ack("R4 vector 0x40+2", 8'h42);
        wr(1'b0, 8'h0B);
        rd(1'b0, "R9 auto-EOI no in-service", 8'h00);
        wr(1'b0, 8'h0A);
        rd(1'b0, "R12 level still set", 8'h04);
        set_irq(8'h00);
        rd(1'b0, "R12 level cleared", 8'h00);
        chk("R12 irq_out low", {7'b0, irq_out}, 8'h00);

        // R3 no mode word
        wr(1'b0, 8'h12);
        chk("R2 mode cleared", {3'b0, cfg_mode}, 8'h00);
        wr(1'b1, 8'h60);
        wr(1'b1, 8'h3C);
        rd(1'b1, "R3 mode skipped, mask loaded", 8'h3C);
        set_irq(8'h01);
        ack("R4 vector 0x60+0", 8'h60);
        rd(1'b0, "R7 edge request cleared", 8'h00);

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule